// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Unit

This block keeps the control and status state for every channel of a multi-channel DMA controller and merges the channels' events into one interrupt line. Each channel owns one 32-bit word that holds its run control, a mode bit that skips descriptor fetch, three interrupt enables and three sticky event flags. The channel engines report start, end, bus-error and stop-reached events as single-cycle pulses. They also report whether they are idle and whether a peripheral request is waiting.

Software reads a channel word and then writes the same value back. This clears exactly the flags it has just seen. A summary word has one bit for each channel whose enabled events are pending. An interrupt handler reads that word first to find the channels to service. The register port is a simple strobed interface with no wait states, and read data returns on the cycle after the read strobe.

Top module: `dma_chan_status_irq`

## Requirements
- R1: After reset every channel has RUN, no-fetch mode, all enables and all flags at 0, `irq` is 0 and `ch_run`/`ch_nodesc` are all 0.
- R2: Channel i's word is at byte offset 4*i and the summary word is at byte offset 0xF0. Read data appears on `reg_rdata` one cycle after `reg_rd`. The channel word layout is: bit 31 RUN, bit 30 no-fetch mode, bit 29 stop interrupt enable, bit 22 start interrupt enable, bit 21 end interrupt enable, bit 8 request pending, bit 3 stop state, bit 2 end flag, bit 1 start flag, bit 0 bus-error flag. All other bits read 0.
- R3: A pulse on `ev_buserr[i]`, `ev_start[i]` or `ev_end[i]` sets flag bit 0, 1 or 2 of channel i, and the flag stays set until it is cleared.
- R4: Writing a channel word clears each flag whose bit in the written data is 1 and leaves each flag whose bit is 0 unchanged.
- R5: When an event pulse arrives in the same cycle as a write that clears its flag, the flag ends up set.
- R6: Bits 8 and 3 are read-only and writes to them have no effect. Bit 8 reflects `req_pend[i]`.
- R7: Bit 3 (stop state) reads 1 exactly when RUN is 0 and `eng_idle[i]` is 1.
- R8: Bits 31 and 30 are written by software and drive `ch_run[i]` and `ch_nodesc[i]`. A pulse on `ev_stop[i]` clears RUN, and it takes precedence over a write of RUN in the same cycle.
- R9: Channel i's summary bit is bus-error flag OR (start flag AND start enable) OR (end flag AND end enable) OR (stop state AND stop enable).
- R10: `irq` is the OR of all summary bits, registered, so it follows the summary one cycle later.
- R11: A read of an address that is neither a channel word nor the summary word, or that is not word aligned, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| ev_start | input | NUM_CH | Per-channel start event pulse |
| ev_end | input | NUM_CH | Per-channel end event pulse |
| ev_buserr | input | NUM_CH | Per-channel bus error pulse |
| ev_stop | input | NUM_CH | Per-channel stop-reached pulse |
| eng_idle | input | NUM_CH | Channel engine reports idle |
| req_pend | input | NUM_CH | Peripheral request waiting on the channel |
| ch_run | output | NUM_CH | RUN control per channel |
| ch_nodesc | output | NUM_CH | No-descriptor-fetch mode per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: 32 channels and an 8-bit address. At this width the highest channel lands on the top bit of the summary word, and the first unused word at 0x80 lies between the last channel and the summary. Events are placed on channels 0, 31 and a spread in between. The bench checks the races that matter to a handler: a clear against a fresh event, and RUN set against a stop report in the same cycle. It also checks that the interrupt only drops once the last of several channels has been cleared.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned WORD_W      = 32;
  // channel word bit positions (software decodes these)
  localparam int unsigned B_RUN       = 31;
  localparam int unsigned B_NODESC    = 30;
  localparam int unsigned B_STOP_EN   = 29;
  localparam int unsigned B_START_EN  = 22;
  localparam int unsigned B_END_EN    = 21;
  localparam int unsigned B_REQ       = 8;
  localparam int unsigned B_STOP_ST   = 3;
  localparam int unsigned B_END_F     = 2;
  localparam int unsigned B_START_F   = 1;
  localparam int unsigned B_ERR_F     = 0;
  localparam int unsigned SUM_OFFSET  = 32'h0000_00F0;
endpackage

// File: rtl/dma_ch_csr.sv
module dma_ch_csr
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ev_start,
  input  logic              ev_end,
  input  logic              ev_err,
  input  logic              ev_stop,
  input  logic              idle,
  input  logic              req,
  output logic [WORD_W-1:0] word,
  output logic              run,
  output logic              nodesc,
  output logic              pend
);
  logic       stop_en, start_en, end_en;
  logic [2:0] flags, flags_nxt, ev_vec;
  logic       stop_st;

  assign ev_vec = {ev_end, ev_start, ev_err};

  always_comb begin
    flags_nxt = flags;
    if (wr_hit) flags_nxt = flags & ~wdata[B_END_F:B_ERR_F];
    flags_nxt = flags_nxt | ev_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      nodesc   <= 1'b0;
      stop_en  <= 1'b0;
      start_en <= 1'b0;
      end_en   <= 1'b0;
      flags    <= '0;
    end else begin
      if (wr_hit) begin
        run      <= wdata[B_RUN];
        nodesc   <= wdata[B_NODESC];
        stop_en  <= wdata[B_STOP_EN];
        start_en <= wdata[B_START_EN];
        end_en   <= wdata[B_END_EN];
      end
      if (ev_stop) run <= 1'b0;
      flags <= flags_nxt;
    end
  end

  assign stop_st = ~run & idle;

  always_comb begin
    word             = '0;
    word[B_RUN]      = run;
    word[B_NODESC]   = nodesc;
    word[B_STOP_EN]  = stop_en;
    word[B_START_EN] = start_en;
    word[B_END_EN]   = end_en;
    word[B_REQ]      = req;
    word[B_STOP_ST]  = stop_st;
    word[B_END_F:B_ERR_F] = flags;
  end

  assign pend = flags[0] | (flags[1] & start_en) | (flags[2] & end_en)
              | (stop_st & stop_en);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[28:23], wdata[20:3]};

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> word[B_ERR_F]);
  // R4
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wdata[B_END_F] && !ev_end) |=> !word[B_END_F]);
  // R5
  end_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ev_end |=> word[B_END_F]);
  // R8
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !run);
endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pend,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|pend));
  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !irq);
endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_CH-1:0][WORD_W-1:0] ch_words,
  input  logic [NUM_CH-1:0]             summary,
  output logic [NUM_CH-1:0]             wr_hit,
  output logic [WORD_W-1:0]             rdata
);
  localparam int unsigned WIDX_W   = ADDR_W - 2;
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned SUM_WIDX = SUM_OFFSET / 4;

  logic [WIDX_W-1:0] widx;
  logic              aligned, is_ch, is_sum;
  logic [CH_W-1:0]   ch_sel;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign is_ch   = aligned && (32'(widx) < NUM_CH);
  assign is_sum  = aligned && (32'(widx) == SUM_WIDX);
  assign ch_sel  = widx[CH_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_hit
      assign wr_hit[gi] = wr && aligned && (widx == WIDX_W'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (is_ch)       rdata <= ch_words[ch_sel];
      else if (is_sum) rdata <= WORD_W'(summary);
      else             rdata <= '0;
    end
  end

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !is_ch && !is_sum) |=> (rdata == '0));
endmodule

// File: rtl/dma_chan_status_irq.sv
module dma_chan_status_irq
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] ev_start,
  input  logic [NUM_CH-1:0] ev_end,
  input  logic [NUM_CH-1:0] ev_buserr,
  input  logic [NUM_CH-1:0] ev_stop,
  input  logic [NUM_CH-1:0] eng_idle,
  input  logic [NUM_CH-1:0] req_pend,
  output logic [NUM_CH-1:0] ch_run,
  output logic [NUM_CH-1:0] ch_nodesc,
  output logic              irq
);
  logic [NUM_CH-1:0][WORD_W-1:0] ch_words;
  logic [NUM_CH-1:0]             pend;
  logic [NUM_CH-1:0]             wr_hit;

  dma_reg_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .ch_words (ch_words),
    .summary  (pend),
    .wr_hit   (wr_hit),
    .rdata    (reg_rdata)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      dma_ch_csr u_ch (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit[gi]),
        .wdata    (reg_wdata),
        .ev_start (ev_start[gi]),
        .ev_end   (ev_end[gi]),
        .ev_err   (ev_buserr[gi]),
        .ev_stop  (ev_stop[gi]),
        .idle     (eng_idle[gi]),
        .req      (req_pend[gi]),
        .word     (ch_words[gi]),
        .run      (ch_run[gi]),
        .nodesc   (ch_nodesc[gi]),
        .pend     (pend[gi])
      );
    end
  endgenerate

  dma_irq_combine #(.NUM_CH(NUM_CH)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .pend (pend),
    .irq  (irq)
  );

  // R9
  buserr_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (|ev_buserr) |=> (|pend));
endmodule

// File: tb/dma_chan_status_irq_tb.sv
module dma_chan_status_irq_tb;
  localparam int NCH = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] ev_start = '0, ev_end = '0, ev_buserr = '0, ev_stop = '0;
  logic [NCH-1:0] eng_idle = '1, req_pend = '0, ch_run, ch_nodesc;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  dma_chan_status_irq u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_start(ev_start), .ev_end(ev_end), .ev_buserr(ev_buserr),
    .ev_stop(ev_stop), .eng_idle(eng_idle), .req_pend(req_pend),
    .ch_run(ch_run), .ch_nodesc(ch_nodesc), .irq(irq)
  );

  // vector: [11:4] channel, [2:0] events {end,start,buserr}
  localparam logic [11:0] VEC [6] = '{12'h001, 12'h052, 12'h114,
                                      12'h1F7, 12'h0C3, 12'h030};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(input int ch, input logic [2:0] ev, input logic stop);
    @(negedge clk);
    ev_buserr[ch] = ev[0]; ev_start[ch] = ev[1]; ev_end[ch] = ev[2]; ev_stop[ch] = stop;
    @(negedge clk);
    ev_buserr = '0; ev_start = '0; ev_end = '0; ev_stop = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 run", 32'(ch_run), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(8'h00, v); chk("R1 ch0 word", v, 32'h8);
    rd(8'hF0, v); chk("R1 summary", v, 0);

    // table walk: R3 set, R4 clear, R9 summary
    for (int k = 0; k < 6; k++) begin
      int ch;
      logic [2:0] ev;
      ch = int'(VEC[k][11:4]);
      ev = VEC[k][2:0];
      pulse(ch, ev, 1'b0);
      rd(8'(ch * 4), v); chk("R3 flags set", v, 32'h8 | 32'(ev));
      rd(8'hF0, v); chk("R9 summary bus error", v, ev[0] ? (32'h1 << ch) : 32'h0);
      wr(8'(ch * 4), 32'(ev));
      rd(8'(ch * 4), v); chk("R4 flags cleared", v, 32'h8);
    end

    // R4 writing zero keeps a flag
    pulse(2, 3'b001, 1'b0);
    wr(8'h08, 32'h0);
    rd(8'h08, v); chk("R4 zero keeps flag", v, 32'h9);
    wr(8'h08, 32'h1);

    // R5 event beats simultaneous clear
    pulse(4, 3'b100, 1'b0);
    @(negedge clk); reg_wr = 1; reg_addr = 8'h10; reg_wdata = 32'h4; ev_end[4] = 1;
    @(negedge clk); reg_wr = 0; ev_end = '0;
    rd(8'h10, v); chk("R5 set wins over clear", v, 32'hC);
    wr(8'h10, 32'h4);

    // R6 read-only bits, R7 stop state
    req_pend[6] = 1;
    wr(8'h18, 32'h108);
    rd(8'h18, v); chk("R6 read-only bits", v, 32'h108);
    req_pend[6] = 0; eng_idle[6] = 0;
    rd(8'h18, v); chk("R7 not idle no stop state", v, 32'h0);
    eng_idle[6] = 1;

    // R8 run control and stop event
    wr(8'h1C, 32'h8000_0000);
    chk("R8 ch_run set", 32'(ch_run[7]), 1);
    rd(8'h1C, v); chk("R7 running no stop state", v, 32'h8000_0000);
    pulse(7, 3'b000, 1'b1);
    chk("R8 stop clears run", 32'(ch_run[7]), 0);
    rd(8'h1C, v); chk("R7 stopped idle", v, 32'h8);
    @(negedge clk); reg_wr = 1; reg_addr = 8'h38; reg_wdata = 32'h8000_0000; ev_stop[14] = 1;
    @(negedge clk); reg_wr = 0; ev_stop = '0;
    chk("R8 stop beats run write", 32'(ch_run[14]), 0);
    wr(8'h34, 32'h4000_0000);
    chk("R8 nodesc out", 32'(ch_nodesc[13]), 1);
    rd(8'h34, v); chk("R2 nodesc bit", v, 32'h4000_0008);

    // R9 stop interrupt enable, R10 irq
    wr(8'h24, 32'h2000_0000);
    @(negedge clk);
    chk("R10 irq from stop", 32'(irq), 1);
    rd(8'hF0, v); chk("R9 stop pending", v, 32'h200);
    wr(8'h24, 32'h0);
    @(negedge clk);
    chk("R10 irq drops", 32'(irq), 0);

    // R9 end enable gating
    pulse(10, 3'b100, 1'b0);
    rd(8'hF0, v); chk("R9 end masked", v, 0);
    wr(8'h28, 32'h0020_0000);
    rd(8'hF0, v); chk("R9 end enabled", v, 32'h400);
    wr(8'h28, 32'h0020_0004);
    rd(8'hF0, v); chk("R9 end cleared", v, 0);
    wr(8'h2C, 32'h0040_0000);
    pulse(11, 3'b010, 1'b0);
    rd(8'hF0, v); chk("R9 start enabled", v, 32'h800);
    wr(8'h2C, 32'h2);
    rd(8'hF0, v); chk("R9 start cleared", v, 0);

    // R10 OR over channels
    pulse(0, 3'b001, 1'b0);
    pulse(31, 3'b001, 1'b0);
    rd(8'hF0, v); chk("R2 summary edges", v, 32'h8000_0001);
    wr(8'h00, 32'h1);
    @(negedge clk);
    chk("R10 irq held by ch31", 32'(irq), 1);
    wr(8'h7C, 32'h1);
    @(negedge clk);
    chk("R10 irq clear", 32'(irq), 0);

    // R11 unmapped and unaligned
    rd(8'h80, v); chk("R11 gap reads zero", v, 0);
    rd(8'hF4, v); chk("R11 above summary", v, 0);
    rd(8'h01, v); chk("R11 unaligned", v, 0);

    finish_run();
  end
endmodule